// File: doc/BRIEF.md
# Switch Entry Bus Peripheral

This block lets a user key binary numbers into a processor system. Sixteen slide switches hold a value and two push buttons act as "enter" keys. When a button goes down, the value on the switches at that moment is latched into a 16-bit holding register that belongs to that button. Switch positions passed through while the user is still moving the switches therefore never reach software.

Each button also has a pending flag. The flag goes up when the button latches a value. It comes down when software reads that button's holding register. Software polls the flag word, reads the value it points to, and so sees every entry exactly once, including the same number entered several times in a row.

The block is a slave on an AHB-Lite bus. It never inserts wait states. Every register is read-only, and bus writes change nothing. The switch and button inputs are synchronised inside the block, but contact bounce is not filtered.

Top module: `swi_entry_top`

## Requirements
- R1: Out of reset, both holding registers read 0 and the flag word reads 0.
- R2: A rising button input latches the synchronised switch value into that button's own holding register: button 0 at byte offset 0x0, button 1 at offset 0x4. The latch happens on the third rising clock edge after the button is first sampled high. The other button's register is unchanged.
- R3: The flag word at offset 0x8 has bit 0 for button 0 and bit 1 for button 1. A latch sets the button's bit, and bits 31..2 read 0.
- R4: A read of a holding register returns its 16-bit value zero-extended on hrdata in the data phase. The read clears only that button's flag bit.
- R5: Reading the flag word does not change any flag.
- R6: Write transfers to any offset change no holding register and no flag.
- R7: Switch changes made while no button rises never alter a holding register.
- R8: A button held down latches once only; later switch changes during the same press are not captured.
- R9: When a latch and the data phase of a read of the same register coincide, the read returns the old value, the register takes the new value and the flag stays 1.
- R10: hreadyout is always 1 and hresp is always 0 (OKAY).
- R11: Transfers with hsel low or htrans IDLE/BUSY (htrans[1]=0) have no effect on flags.
- R12: A read of offset 0xC returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| hsel | input | 1 | Slave select |
| haddr | input | 32 | Transfer address; bits 3:2 pick the register |
| hwrite | input | 1 | 1 = write transfer |
| htrans | input | 2 | Transfer type |
| hready | input | 1 | Bus ready (previous transfer done) |
| hwdata | input | 32 | Write data, discarded |
| hrdata | output | 32 | Read data in data phase |
| hreadyout | output | 1 | Always 1 |
| hresp | output | 1 | Always OKAY (0) |
| sw_in | input | 16 | Asynchronous switch levels |
| btn_in | input | 2 | Asynchronous button levels |

## Verification
The assertions rely on two assumptions: the button and switch levels reach the latch logic only through the synchroniser, and a read clears a flag only in the data phase of a registered address phase. The stimulus drives every input at the falling clock edge and keeps hready at 1. It holds each button level for several cycles, so no edge is lost in the synchroniser. Random presses, reads, writes and idle transfers are mixed with a read timed so that its data phase lands on the latching edge.

// File: rtl/swi_pkg.sv
package swi_pkg;
  localparam int unsigned NUM_BTN = 2;
  typedef enum logic [1:0] {
    REG_DATA0 = 2'd0,
    REG_DATA1 = 2'd1,
    REG_STAT  = 2'd2,
    REG_NONE  = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/swi_sync.sv
module swi_sync #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/swi_chan.sv
module swi_chan #(
  parameter int unsigned SW_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            btn_s,
  input  logic [SW_W-1:0] sw_s,
  input  logic            rd_clr,
  output logic [SW_W-1:0] data,
  output logic            flag
);
  logic btn_q;
  logic rise;

  assign rise = btn_s & ~btn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      btn_q <= 1'b0;
      data  <= '0;
      flag  <= 1'b0;
    end else begin
      btn_q <= btn_s;
      if (rise) data <= sw_s;
      if (rise)        flag <= 1'b1;
      else if (rd_clr) flag <= 1'b0;
    end
  end

  AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (rst)
    rise |=> data == $past(sw_s)); // R2
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    rise |=> flag); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !rise) |=> !flag); // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(data)); // R7
  AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!flag && !rise) |=> !flag); // R6
  AST_ONE_LATCH_PER_PRESS: assert property (@(posedge clk) disable iff (rst)
    (btn_s && btn_q) |=> $stable(data)); // R8
endmodule

// File: rtl/swi_bus.sv
module swi_bus
  import swi_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic              hwrite,
  input  logic [1:0]        htrans,
  input  logic              hready,
  output logic              rd_act,
  output reg_idx_e          rd_idx
);
  localparam int unsigned IDX_LSB = 2;

  logic unused_addr_bits;
  assign unused_addr_bits = ^{haddr[ADDR_W-1:IDX_LSB+2], haddr[IDX_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act <= 1'b0;
      rd_idx <= REG_NONE;
    end else if (hready) begin
      rd_act <= hsel & htrans[1] & ~hwrite;
      rd_idx <= reg_idx_e'(haddr[IDX_LSB+1:IDX_LSB]);
    end
  end

  AST_IDLE_NO_ACT: assert property (@(posedge clk) disable iff (rst)
    (hready && !(hsel && htrans[1])) |=> !rd_act); // R11
  AST_WRITE_NO_ACT: assert property (@(posedge clk) disable iff (rst)
    (hready && hwrite) |=> !rd_act); // R6
endmodule

// File: rtl/swi_entry_top.sv
module swi_entry_top
  import swi_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SW_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic              hwrite,
  input  logic [1:0]        htrans,
  input  logic              hready,
  input  logic [DATA_W-1:0] hwdata,
  output logic [DATA_W-1:0] hrdata,
  output logic              hreadyout,
  output logic              hresp,
  input  logic [SW_W-1:0]   sw_in,
  input  logic [1:0]        btn_in
);
  localparam int unsigned SYNC_W = SW_W + NUM_BTN;

  logic unused_wdata;
  assign unused_wdata = ^hwdata;

  logic [SYNC_W-1:0] sync_q;
  logic [SW_W-1:0]   sw_s;
  logic [NUM_BTN-1:0] btn_s;

  swi_sync #(.W(SYNC_W)) u_sync (
    .clk(clk), .rst(rst), .d({btn_in, sw_in}), .q(sync_q)
  );
  assign sw_s  = sync_q[SW_W-1:0];
  assign btn_s = sync_q[SYNC_W-1:SW_W];

  logic     rd_act;
  reg_idx_e rd_idx;

  swi_bus #(.ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst(rst), .hsel(hsel), .haddr(haddr), .hwrite(hwrite),
    .htrans(htrans), .hready(hready), .rd_act(rd_act), .rd_idx(rd_idx)
  );

  logic [SW_W-1:0]    chan_data [NUM_BTN];
  logic [NUM_BTN-1:0] chan_flag;

  for (genvar i = 0; i < NUM_BTN; i++) begin : g_chan
    logic clr;
    assign clr = rd_act && (rd_idx == reg_idx_e'(i));
    swi_chan #(.SW_W(SW_W)) u_chan (
      .clk(clk), .rst(rst), .btn_s(btn_s[i]), .sw_s(sw_s),
      .rd_clr(clr), .data(chan_data[i]), .flag(chan_flag[i])
    );
  end

  always_comb begin
    hrdata = '0;
    if (rd_act) begin
      case (rd_idx)
        REG_DATA0: hrdata = {{(DATA_W-SW_W){1'b0}}, chan_data[0]};
        REG_DATA1: hrdata = {{(DATA_W-SW_W){1'b0}}, chan_data[1]};
        REG_STAT:  hrdata = {{(DATA_W-NUM_BTN){1'b0}}, chan_flag};
        default:   hrdata = '0;
      endcase
    end
  end

  assign hreadyout = 1'b1;
  assign hresp     = 1'b0;

  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_act && rd_idx == REG_STAT) |-> hrdata[DATA_W-1:NUM_BTN] == '0); // R3
  AST_SPARE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_act && rd_idx == REG_NONE) |-> hrdata == '0); // R12
endmodule

// File: tb/swi_entry_top_test.sv
module swi_entry_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hsel = 1'b0;
  logic [31:0] haddr = '0;
  logic        hwrite = 1'b0;
  logic [1:0]  htrans = 2'b00;
  logic        hready = 1'b1;
  logic [31:0] hwdata = '0;
  logic [31:0] hrdata;
  logic        hreadyout, hresp;
  logic [15:0] sw_in = '0;
  logic [1:0]  btn_in = '0;

  int tests = 0;
  int fails = 0;
  logic [15:0] m_data [2];
  logic [1:0]  m_flag;

  always #4 clk = ~clk;

  swi_entry_top uut (
    .clk(clk), .rst(rst), .hsel(hsel), .haddr(haddr), .hwrite(hwrite),
    .htrans(htrans), .hready(hready), .hwdata(hwdata), .hrdata(hrdata),
    .hreadyout(hreadyout), .hresp(hresp), .sw_in(sw_in), .btn_in(btn_in)
  );

  function automatic logic [31:0] model_read(input logic [3:0] off);
    case (off[3:2])
      2'd0: return {16'h0, m_data[0]};
      2'd1: return {16'h0, m_data[1]};
      2'd2: return {30'h0, m_flag};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_read(input logic [3:0] off, output logic [31:0] d);
    hsel = 1'b1; haddr = {28'h0, off}; hwrite = 1'b0; htrans = 2'b10;
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00;
    d = hrdata;
    check(hreadyout === 1'b1 && hresp === 1'b0, "R10", {30'h0, hreadyout, hresp}, 32'h2);
    @(negedge clk);
  endtask

  task automatic read_check(input logic [3:0] off, input string req);
    logic [31:0] d, e;
    e = model_read(off);
    bus_read(off, d);
    check(d === e, req, d, e);
    if (off[3:2] < 2'd2) m_flag[off[2]] = 1'b0;
  endtask

  task automatic bus_write(input logic [3:0] off, input logic [31:0] v);
    hsel = 1'b1; haddr = {28'h0, off}; hwrite = 1'b1; htrans = 2'b10;
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hwdata = v;
    @(negedge clk);
  endtask

  task automatic press(input int b, input logic [15:0] v);
    sw_in = v;
    cyc(3);
    btn_in[b] = 1'b1;
    cyc(5);
    m_data[b] = v; m_flag[b] = 1'b1;
    btn_in[b] = 1'b0;
    cyc(4);
  endtask

  initial begin
    cyc(100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    m_data[0] = '0; m_data[1] = '0; m_flag = '0;
    cyc(4);
    rst = 1'b0;
    cyc(2);
    // R1 reset state
    read_check(4'h8, "R1");
    read_check(4'h0, "R1");
    read_check(4'h4, "R1");
    // R7 switches alone do nothing
    sw_in = 16'hBEEF; cyc(6);
    read_check(4'h0, "R7");
    read_check(4'h8, "R7");
    // R2 / R3 capture on each button
    press(0, 16'h1234);
    read_check(4'h8, "R3");
    read_check(4'h8, "R5");
    press(1, 16'hA5A5);
    read_check(4'h8, "R3");
    read_check(4'h4, "R4");
    read_check(4'h8, "R4");
    read_check(4'h0, "R2");
    read_check(4'h8, "R4");
    // R3 repeated identical entry is seen again
    press(0, 16'h1234);
    read_check(4'h8, "R3");
    read_check(4'h0, "R2");
    // R6 writes ignored
    press(1, 16'h0F0F);
    bus_write(4'h0, 32'hFFFF_FFFF);
    bus_write(4'h4, 32'h0);
    bus_write(4'h8, 32'h0);
    read_check(4'h8, "R6");
    read_check(4'h4, "R6");
    // R11 idle / unselected transfers do not clear
    press(0, 16'h7777);
    hsel = 1'b1; haddr = 32'h0; htrans = 2'b00; cyc(1);
    hsel = 1'b0; htrans = 2'b10; cyc(1);
    htrans = 2'b01; hsel = 1'b1; cyc(1);
    hsel = 1'b0; htrans = 2'b00; cyc(1);
    read_check(4'h8, "R11");
    // R12 spare offset
    read_check(4'hC, "R12");
    read_check(4'h0, "R4");
    // R8 held button latches once
    sw_in = 16'h0101; cyc(3);
    btn_in[1] = 1'b1; cyc(5);
    m_data[1] = 16'h0101; m_flag[1] = 1'b1;
    sw_in = 16'h0202; cyc(6);
    btn_in[1] = 1'b0; cyc(4);
    read_check(4'h4, "R8");
    // R9 latch coincides with read data phase
    sw_in = 16'hC0DE; cyc(3);
    btn_in[0] = 1'b1;
    @(negedge clk);
    hsel = 1'b1; haddr = 32'h0; hwrite = 1'b0; htrans = 2'b10;
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00;
    d = hrdata;
    check(d === {16'h0, m_data[0]}, "R9", d, {16'h0, m_data[0]});
    @(negedge clk);
    m_data[0] = 16'hC0DE; m_flag[0] = 1'b1;
    cyc(3); btn_in[0] = 1'b0; cyc(4);
    read_check(4'h8, "R9");
    read_check(4'h0, "R9");
    // random mix
    for (int i = 0; i < 60; i++) begin
      int unsigned op;
      op = $urandom_range(0, 3);
      case (op)
        0: press(int'($urandom_range(0, 1)), 16'($urandom));
        1: read_check({$urandom_range(0, 3), 2'b00}, "R4");
        2: bus_write({$urandom_range(0, 3), 2'b00}, $urandom);
        default: read_check(4'h8, "R5");
      endcase
    end
    read_check(4'h0, "R2");
    read_check(4'h4, "R2");
    read_check(4'h8, "R3");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule